// File: doc/BRIEF.md
# PWM Event Action Qualifier

This block turns the events of an external PWM counter into two PWM outputs, A and B. Each clock it receives the counter value, the count direction and single-cycle strobes that mark counter-at-zero and counter-at-period. It keeps two compare values, each as a shadow register that software writes and an active register that the match logic uses. From these it derives seven qualified events: zero, period, compare-A match while counting up, compare-A match while counting down, the same two for compare-B, and a software force. Each output has its own force strobe.

Each output has its own 14-bit action table. The table gives every event a 2-bit action: hold, drive low, drive high or invert. When several events occur in one cycle, a fixed priority selects the action that is applied. Any one event can also be chosen to raise a one-cycle start-of-conversion pulse for an ADC.

Top module: `pwm_aq`

## Requirements
- R1: While `rstN` is low and after reset, `pwmA`, `pwmB` and `socPulse` are 0, and both active compare values are 0.
- R2: Action codes are 00 hold, 01 drive low, 10 drive high and 11 invert. The output register takes the resolved action at the clock edge where the event is presented. With only hold actions in a table, that output does not change.
- R3: The table fields are zero [1:0], period [3:2], compare-A up [5:4], compare-A down [7:6], compare-B up [9:8], compare-B down [11:10] and force [13:12]. A compare-A match (`cntVal` equals active compare-A) uses the up field when `cntUp`=1 and the down field when `cntUp`=0.
- R4: A compare-B match uses the compare-B up field or the compare-B down field in the same way, based on `cntUp`.
- R5: `actTblA` drives only `pwmA` and `actTblB` drives only `pwmB`. An event whose action in one table is hold leaves that output unchanged, whatever the other table does.
- R6: A pulse on `cmpAWr` or `cmpBWr` writes `cmpWrData` into the shadow register. The active value is copied from the shadow only in a cycle with `cntZero`=1, and it holds at every other time. Matches in the zero cycle use the active value from before the copy.
- R7: A one-cycle pulse on `forceA` or `forceB` applies the force field of that output's table at the next rising clock edge. It does not affect the other output.
- R8: Events that occur together resolve in this order, highest first: force, compare-B, compare-A, zero, period. An event whose action is hold does not take part, so the next lower active event with a non-hold action decides.
- R9: The invert action (11) complements the output each time its event occurs.
- R10: `socSel` selects the event for the start-of-conversion pulse: 0 zero, 1 period, 2 compare-A up, 3 compare-A down, 4 compare-B up, 5 compare-B down, 6 either force, 7 off. `socPulse` is high for exactly the one cycle after the edge at which the selected event was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | 16 | Counter value from the time base |
| cntUp | input | 1 | 1 when counting up, 0 when counting down |
| cntZero | input | 1 | Counter-equals-zero strobe |
| cntPeriod | input | 1 | Counter-equals-period strobe |
| cmpAWr | input | 1 | Write strobe for compare-A shadow |
| cmpBWr | input | 1 | Write strobe for compare-B shadow |
| cmpWrData | input | 16 | Compare shadow write data |
| actTblA | input | 14 | Action table for output A |
| actTblB | input | 14 | Action table for output B |
| forceA | input | 1 | Software force for output A |
| forceB | input | 1 | Software force for output B |
| socSel | input | 3 | Start-of-conversion event select |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |
| socPulse | output | 1 | ADC start-of-conversion pulse |

## Verification
The bench presents the counter at a compare value in both directions and also one count away from it. This separates up-count matches from down-count matches and shows that a near miss does not match. It writes a new compare shadow and then counts through both the old and the new value before and after a zero strobe, which shows whether the active copy is loaded too early. Coincident events are built up one at a time (zero with compare-A, then compare-B added, then force added, then compare-B set to hold, then zero with period), so that each step of the priority order and the rule that hold actions do not take part give a different output value. Start-of-conversion selection is checked with the selected event present, with its direction reversed, and with the pulse turned off.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int NUM_EVT = 7;
  localparam int ACT_W   = 2;
  localparam int TBL_W   = NUM_EVT * ACT_W;
  localparam int SEL_W   = 3;

  // event slot indices inside an action table (field order is decoded)
  localparam int EV_ZERO = 0;
  localparam int EV_PRD  = 1;
  localparam int EV_CAU  = 2;
  localparam int EV_CAD  = 3;
  localparam int EV_CBU  = 4;
  localparam int EV_CBD  = 5;
  localparam int EV_FRC  = 6;

  localparam logic [SEL_W-1:0] SOC_FORCE = 3'd6;
  localparam logic [SEL_W-1:0] SOC_OFF   = 3'd7;

  typedef enum logic [ACT_W-1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_INV  = 2'b11
  } act_e;

  // strobes from control to datapath
  typedef struct packed {
    logic frcB;
    logic frcA;
    logic cbDn;
    logic cbUp;
    logic caDn;
    logic caUp;
    logic prd;
    logic zero;
  } evt_t;

  // resolution order: position 0 is lowest priority, last is highest
  function automatic int prioSlot(input int pos);
    case (pos)
      0:       prioSlot = EV_PRD;
      1:       prioSlot = EV_ZERO;
      2:       prioSlot = EV_CAD;
      3:       prioSlot = EV_CAU;
      4:       prioSlot = EV_CBD;
      5:       prioSlot = EV_CBU;
      default: prioSlot = EV_FRC;
    endcase
  endfunction

endpackage

// File: rtl/pwm_aq_ctrl.sv
module pwm_aq_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntUp,
  input  logic             cntZero,
  input  logic             cntPeriod,
  input  logic             cmpAWr,
  input  logic             cmpBWr,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             forceA,
  input  logic             forceB,
  output evt_t             evt
);

  logic [CNT_W-1:0] cmpShdA, cmpShdB;
  logic [CNT_W-1:0] cmpActA, cmpActB;
  logic             hitA, hitB;

  // shadow registers written by software
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpShdA <= '0;
      cmpShdB <= '0;
    end else begin
      if (cmpAWr) cmpShdA <= cmpWrData;
      if (cmpBWr) cmpShdB <= cmpWrData;
    end
  end

  // active copies follow the shadows only at counter zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpActA <= '0;
      cmpActB <= '0;
    end else if (cntZero) begin
      cmpActA <= cmpShdA;
      cmpActB <= cmpShdB;
    end
  end

  assign hitA = (cntVal == cmpActA);
  assign hitB = (cntVal == cmpActB);

  always_comb begin
    evt      = '0;
    evt.zero = cntZero;
    evt.prd  = cntPeriod;
    evt.caUp = hitA &  cntUp;
    evt.caDn = hitA & ~cntUp;
    evt.cbUp = hitB &  cntUp;
    evt.cbDn = hitB & ~cntUp;
    evt.frcA = forceA;
    evt.frcB = forceB;
  end

  // R6: active compare values move only on a zero strobe
  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cntZero |=> ($stable(cmpActA) && $stable(cmpActB)));

  // R3/R4: one direction at most per compare
  p_dir_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.caUp && evt.caDn) && !(evt.cbUp && evt.cbDn));

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evt_t             evt,
  input  logic             frc,
  input  logic [TBL_W-1:0] tbl,
  output logic             pwmOut
);

  logic [NUM_EVT-1:0] evtVec;
  act_e               actSel;
  logic               nextOut;

  assign evtVec = {frc, evt.cbDn, evt.cbUp, evt.caDn, evt.caUp, evt.prd, evt.zero};

  // walk from lowest to highest priority, later non-hold entries override
  always_comb begin
    actSel = ACT_HOLD;
    for (int pos = 0; pos < NUM_EVT; pos++) begin
      if (evtVec[prioSlot(pos)] &&
          (tbl[prioSlot(pos)*ACT_W +: ACT_W] != ACT_HOLD))
        actSel = act_e'(tbl[prioSlot(pos)*ACT_W +: ACT_W]);
    end
  end

  always_comb begin
    case (actSel)
      ACT_LOW:  nextOut = 1'b0;
      ACT_HIGH: nextOut = 1'b1;
      ACT_INV:  nextOut = ~pwmOut;
      default:  nextOut = pwmOut;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pwmOut <= 1'b0;
    else       pwmOut <= nextOut;
  end

  // R2: no event at all leaves the output alone
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtVec == '0) |=> $stable(pwmOut));

  // R7/R8: a force with a drive-high action always wins
  p_force_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frc && tbl[EV_FRC*ACT_W +: ACT_W] == ACT_HIGH) |=> pwmOut);

  p_force_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frc && tbl[EV_FRC*ACT_W +: ACT_W] == ACT_LOW) |=> !pwmOut);

  // R9: force invert complements the previous level
  p_force_inv_r9: assert property (@(posedge clk) disable iff (!rstN)
    (frc && tbl[EV_FRC*ACT_W +: ACT_W] == ACT_INV) |=> (pwmOut != $past(pwmOut)));

endmodule

// File: rtl/pwm_aq_dp.sv
module pwm_aq_dp
  import pwm_aq_pkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  evt_t                         evt,
  input  logic [NUM_OUT-1:0][TBL_W-1:0] tbls,
  input  logic [SEL_W-1:0]             socSel,
  output logic [NUM_OUT-1:0]           pwmOuts,
  output logic                         socPulse
);

  logic [NUM_OUT-1:0] frcVec;
  logic               socHit;

  assign frcVec = {evt.frcB, evt.frcA};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
    pwm_aq_chan u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .evt    (evt),
      .frc    (frcVec[g]),
      .tbl    (tbls[g]),
      .pwmOut (pwmOuts[g])
    );
  end

  always_comb begin
    case (socSel)
      3'd0:    socHit = evt.zero;
      3'd1:    socHit = evt.prd;
      3'd2:    socHit = evt.caUp;
      3'd3:    socHit = evt.caDn;
      3'd4:    socHit = evt.cbUp;
      3'd5:    socHit = evt.cbDn;
      SOC_FORCE: socHit = |frcVec;
      default: socHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) socPulse <= 1'b0;
    else       socPulse <= socHit;
  end

  // R10: a pulse only follows a cycle that carried some event
  p_soc_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(socPulse) |-> ($past(evt) != '0));

  // R10: the off selection never pulses
  p_soc_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    (socSel == SOC_OFF) |=> !socPulse);

endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             cntUp,
  input  logic             cntZero,
  input  logic             cntPeriod,
  input  logic             cmpAWr,
  input  logic             cmpBWr,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic [13:0]      actTblA,
  input  logic [13:0]      actTblB,
  input  logic             forceA,
  input  logic             forceB,
  input  logic [2:0]       socSel,
  output logic             pwmA,
  output logic             pwmB,
  output logic             socPulse
);

  evt_t            evt;
  logic [1:0]      pwmOuts;
  logic [1:0][TBL_W-1:0] tbls;

  assign tbls = {actTblB, actTblA};

  pwm_aq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cntVal    (cntVal),
    .cntUp     (cntUp),
    .cntZero   (cntZero),
    .cntPeriod (cntPeriod),
    .cmpAWr    (cmpAWr),
    .cmpBWr    (cmpBWr),
    .cmpWrData (cmpWrData),
    .forceA    (forceA),
    .forceB    (forceB),
    .evt       (evt)
  );

  pwm_aq_dp #(.NUM_OUT(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .tbls     (tbls),
    .socSel   (socSel),
    .pwmOuts  (pwmOuts),
    .socPulse (socPulse)
  );

  assign pwmA = pwmOuts[0];
  assign pwmB = pwmOuts[1];

  // R1: outputs low while reset is held
  p_reset_low_r1: assert property (@(posedge clk)
    !rstN |=> (!pwmA && !pwmB && !socPulse));

endmodule

// File: tb/pwm_aq_bench.sv
module pwm_aq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = 16'hFFFF;
  logic        cntUp = 1'b1;
  logic        cntZero = 1'b0;
  logic        cntPeriod = 1'b0;
  logic        cmpAWr = 1'b0;
  logic        cmpBWr = 1'b0;
  logic [15:0] cmpWrData = '0;
  logic [13:0] actTblA = '0;
  logic [13:0] actTblB = '0;
  logic        forceA = 1'b0;
  logic        forceB = 1'b0;
  logic [2:0]  socSel = 3'd7;
  logic        pwmA, pwmB, socPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  localparam logic [15:0] IDLE_CNT = 16'hFFFF;

  always #10 clk = ~clk;

  pwm_aq u_pwm_aq (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .cntUp(cntUp),
    .cntZero(cntZero), .cntPeriod(cntPeriod), .cmpAWr(cmpAWr),
    .cmpBWr(cmpBWr), .cmpWrData(cmpWrData), .actTblA(actTblA),
    .actTblB(actTblB), .forceA(forceA), .forceB(forceB),
    .socSel(socSel), .pwmA(pwmA), .pwmB(pwmB), .socPulse(socPulse)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // present one cycle of counter events, return to idle afterwards
  task automatic step(input logic [15:0] cnt, input logic up, input logic z,
                      input logic p, input logic fa, input logic fb);
    cntVal = cnt; cntUp = up; cntZero = z; cntPeriod = p;
    forceA = fa; forceB = fb;
    tick();
    cntVal = IDLE_CNT; cntZero = 0; cntPeriod = 0; forceA = 0; forceB = 0;
  endtask

  task automatic writeShadow(input logic isB, input logic [15:0] val);
    cmpWrData = val; cmpAWr = ~isB; cmpBWr = isB;
    tick();
    cmpAWr = 0; cmpBWr = 0;
  endtask

  task automatic testReset();
    check("R1", "pwmA in reset", pwmA, 1'b0);
    check("R1", "pwmB in reset", pwmB, 1'b0);
    check("R1", "soc in reset", socPulse, 1'b0);
  endtask

  task automatic testLoad();
    writeShadow(1'b0, 16'd100);
    writeShadow(1'b1, 16'd200);
    step(16'd0, 1, 1, 0, 0, 0);
    check("R2", "hold tables keep A", pwmA, 1'b0);
    check("R2", "hold tables keep B", pwmB, 1'b0);
  endtask

  task automatic testZeroPeriod();
    actTblA = 14'b00_00_00_00_00_01_10;
    step(16'd0, 1, 1, 0, 0, 0);
    check("R2", "zero drives A high", pwmA, 1'b1);
    check("R5", "B ignores A table", pwmB, 1'b0);
    step(16'd500, 1, 0, 1, 0, 0);
    check("R2", "period drives A low", pwmA, 1'b0);
  endtask

  task automatic testCmpA();
    actTblA = 14'b00_00_00_01_10_00_00;
    step(16'd99, 1, 0, 0, 0, 0);
    check("R3", "near miss no change", pwmA, 1'b0);
    step(16'd100, 1, 0, 0, 0, 0);
    check("R3", "CA up sets A", pwmA, 1'b1);
    step(16'd100, 0, 0, 0, 0, 0);
    check("R3", "CA down clears A", pwmA, 1'b0);
    check("R5", "B untouched by CA", pwmB, 1'b0);
  endtask

  task automatic testCmpB();
    actTblA = '0;
    actTblB = 14'b00_11_10_00_00_00_00;
    step(16'd200, 1, 0, 0, 0, 0);
    check("R4", "CB up sets B", pwmB, 1'b1);
    step(16'd200, 0, 0, 0, 0, 0);
    check("R9", "CB down inverts B", pwmB, 1'b0);
    step(16'd200, 0, 0, 0, 0, 0);
    check("R9", "CB down inverts B again", pwmB, 1'b1);
    check("R5", "A hold table", pwmA, 1'b0);
    actTblB = 14'b01_00_00_00_00_00_00;
    step(IDLE_CNT, 1, 0, 0, 0, 1);
    check("R7", "force B low", pwmB, 1'b0);
  endtask

  task automatic testShadow();
    actTblB = '0;
    actTblA = 14'b01_00_00_00_10_00_00;
    writeShadow(1'b0, 16'd50);
    step(16'd50, 1, 0, 0, 0, 0);
    check("R6", "new shadow not yet active", pwmA, 1'b0);
    step(16'd100, 1, 0, 0, 0, 0);
    check("R6", "old value still active", pwmA, 1'b1);
    step(IDLE_CNT, 1, 0, 0, 1, 0);
    check("R7", "force A low", pwmA, 1'b0);
    step(16'd0, 1, 1, 0, 0, 0);
    step(16'd100, 1, 0, 0, 0, 0);
    check("R6", "old value retired at zero", pwmA, 1'b0);
    step(16'd50, 1, 0, 0, 0, 0);
    check("R6", "new value active after zero", pwmA, 1'b1);
  endtask

  task automatic testForce();
    actTblA = 14'b11_00_00_00_00_00_00;
    forceA = 1;
    #1;
    check("R7", "no change before edge", pwmA, 1'b1);
    @(negedge clk);
    forceA = 0;
    check("R7", "force inverts A", pwmA, 1'b0);
    check("R7", "force A leaves B", pwmB, 1'b0);
  endtask

  task automatic testPriority();
    actTblA = '0;
    writeShadow(1'b1, 16'd50);
    step(16'd0, 1, 1, 0, 0, 0);
    actTblA = 14'b00_00_00_00_10_00_01;
    step(16'd50, 1, 1, 0, 0, 0);
    check("R8", "CA beats zero", pwmA, 1'b1);
    actTblA = 14'b00_00_01_00_10_00_10;
    step(16'd50, 1, 1, 0, 0, 0);
    check("R8", "CB beats CA", pwmA, 1'b0);
    actTblA = 14'b11_00_01_00_10_00_10;
    step(16'd50, 1, 1, 0, 1, 0);
    check("R8", "force beats CB", pwmA, 1'b1);
    actTblA = 14'b00_00_00_00_01_00_10;
    step(16'd50, 1, 1, 0, 0, 0);
    check("R8", "hold CB skipped, CA decides", pwmA, 1'b0);
    actTblA = 14'b00_00_00_00_00_01_10;
    step(16'd0, 1, 1, 1, 0, 0);
    check("R8", "zero beats period", pwmA, 1'b1);
  endtask

  task automatic testSoc();
    actTblA = '0; actTblB = '0;
    socSel = 3'd4;
    step(16'd50, 0, 0, 0, 0, 0);
    check("R10", "CB down not selected", socPulse, 1'b0);
    step(16'd50, 1, 0, 0, 0, 0);
    check("R10", "CB up pulses", socPulse, 1'b1);
    step(IDLE_CNT, 1, 0, 0, 0, 0);
    check("R10", "pulse lasts one cycle", socPulse, 1'b0);
    socSel = 3'd0;
    step(16'd0, 1, 1, 0, 0, 0);
    check("R10", "zero pulses", socPulse, 1'b1);
    socSel = 3'd7;
    step(16'd50, 1, 1, 0, 0, 0);
    check("R10", "off never pulses", socPulse, 1'b0);
    socSel = 3'd6;
    step(IDLE_CNT, 1, 0, 0, 0, 1);
    check("R10", "force pulses", socPulse, 1'b1);
    check("R5", "hold force leaves B", pwmB, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testLoad();
    testZeroPeriod();
    testCmpA();
    testCmpB();
    testShadow();
    testForce();
    testPriority();
    testSoc();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule